// File: doc/BRIEF.md
# Bidirectional Halfword DMA Buffer

This block is a small halfword buffer that sits between a local datapath and the system DMA bus. It runs in one of two directions. In fill direction the system side writes halfwords and the local side reads them. In drain direction the local side writes bytes, which a holding register pairs into halfwords, and the system side reads them. A registered DMA request tells the DMA controller when a transfer makes sense for the chosen direction.

A flush request means something different in each direction. In fill direction it empties the buffer: the pointers, the count and the holding register are all cleared. In drain direction it asks for everything that is left to be read out. A lone byte still waiting in the holding register is sent as a halfword with a zero upper byte, and the request stays up until nothing remains.

A register port gives firmware random access to the storage so it can save and restore the buffer's state. It can reach every entry, the holding register and a control register made up of byte-present, count, write pointer and read pointer. Access works only while the buffer is disabled. While it is enabled, writes are ignored and reads of entries and of the holding register return zero. The control register can always be read, so the byte-present bit stays visible.

Top module: `hwf_top`

## Requirements
- R1: After reset the buffer is empty, the control register reads zero, and dma_req is low.
- R2: In fill direction (dir_drain=0), halfwords written with sys_wr are returned in the same order on rd_data, one cycle after each loc_rd pulse.
- R3: In drain direction (dir_drain=1), the first byte written goes into the holding register and sets byte-present, which is control bit 0. The second byte pushes the halfword {second, first} and clears byte-present.
- R4: In drain direction, outside a flush, dma_req is high while two or more halfwords are stored and low otherwise. It follows the state with one cycle of delay.
- R5: A flush in drain direction pushes a lone held byte as a halfword whose low byte is that byte. dma_req stays high while any data remains and falls once the buffer and the holding register are empty.
- R6: A flush in fill direction discards all content. Count, pointers and byte-present read zero, and a later loc_rd returns no stored data.
- R7: While en=1, register writes have no effect, and register reads of entries (addresses 0 to DEPTH-1) and of the holding register (address DEPTH) return zero.
- R8: While en=0, register writes and reads of the entries, of the holding register (low byte) and of the control register (address DEPTH+1) work. The control register holds byte-present in bit 0, count in bits 3:1, write pointer in bits 5:4 and read pointer in bits 7:6. After enabling, the buffer continues from the restored state.
- R9: In fill direction, dma_req is high while at least two entries are free.
- R10: A write to a full buffer and a read from an empty buffer are ignored and leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Buffer enable; also gates register access |
| dir_drain | input | 1 | 0: system writes, local reads; 1: local writes, system reads |
| flush | input | 1 | Flush request pulse |
| sys_wr | input | 1 | System halfword write (fill direction) |
| sys_wdata | input | 16 | System write halfword |
| sys_rd | input | 1 | System halfword read (drain direction) |
| loc_byte_wr | input | 1 | Local byte write (drain direction) |
| loc_byte | input | 8 | Local byte |
| loc_rd | input | 1 | Local halfword read (fill direction) |
| rd_data | output | 16 | Halfword read out, registered |
| dma_req | output | 1 | Registered DMA request |
| full | output | 1 | All entries occupied |
| empty | output | 1 | No entry occupied |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: entries, holding, control |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered register read data |

## Verification
The fill direction is driven with four halfwords and then a fifth, which must be rejected. Reading them back shows the ordering, the full boundary and the request threshold on free space. A further read on empty must be ignored. The drain direction is driven with byte pairs, which show the byte order and byte-present. A flush with an odd byte left over separates padding and the request during the flush from the normal threshold on stored halfwords. A fill flush with data present must discard it. A save-and-restore sequence loads entries, pointers, count and a held byte while disabled, then tries to overwrite while enabled. It then drains the restored data, which shows that the gating works and that the loaded pointers are really used.

// File: rtl/hwf_pkg.sv
package hwf_pkg;
  typedef enum logic {
    DIR_FILL  = 1'b0,
    DIR_DRAIN = 1'b1
  } hwf_dir_e;

  function automatic int ctrl_cnt_lsb();
    return 1;
  endfunction
endpackage

// File: rtl/hwf_store.sv
module hwf_store #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  input  logic             ld_state,
  input  logic [CNT_W-1:0] ld_cnt,
  input  logic [PTR_W-1:0] ld_wptr,
  input  logic [PTR_W-1:0] ld_rptr,
  input  logic             reg_we,
  input  logic [PTR_W-1:0] reg_idx,
  input  logic [W-1:0]     reg_wdata,
  output logic [W-1:0]     reg_entry,
  output logic [CNT_W-1:0] cnt,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output logic [W-1:0]     rd_q
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic push_ok, pop_ok;

  assign push_ok = push && !clear && !ld_state && (cnt != FULL_CNT);
  assign pop_ok  = pop  && !clear && !ld_state && (cnt != '0);
  assign reg_entry = mem[reg_idx];

  // single write port so the array maps to RAM
  always_ff @(posedge clk) begin
    if (push_ok)     mem[wptr]    <= push_data;
    else if (reg_we) mem[reg_idx] <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      rd_q <= '0;
    end else if (clear) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (ld_state) begin
      wptr <= ld_wptr;
      rptr <= ld_rptr;
      cnt  <= ld_cnt;
    end else begin
      if (push_ok) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop_ok) begin
        rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
        rd_q <= mem[rptr];
      end
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !clear && !ld_state && cnt == FULL_CNT) |=> (cnt == FULL_CNT));
  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !clear && !ld_state && cnt == '0) |=> (cnt == '0));
  assert_count_bound_R10: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_CNT);
endmodule

// File: rtl/hwf_pack.sv
module hwf_pack #(
  parameter int W = 16,
  localparam int BW = W / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          active,
  input  logic          byte_wr,
  input  logic [BW-1:0] byte_in,
  input  logic          flushing,
  input  logic          full,
  input  logic          ld_state,
  input  logic          ld_bp,
  input  logic          ld_hold,
  input  logic [BW-1:0] ld_hold_val,
  output logic          bp,
  output logic [BW-1:0] hold,
  output logic          push,
  output logic [W-1:0]  push_data
);
  logic take_lo, take_hi, pad;

  assign take_lo = active && !flushing && byte_wr && !bp;
  assign take_hi = active && !flushing && byte_wr && bp && !full;
  assign pad     = active && flushing && bp && !full;

  assign push      = take_hi || pad;
  assign push_data = pad ? {{BW{1'b0}}, hold} : {byte_in, hold};

  always_ff @(posedge clk) begin
    if (rst) begin
      bp   <= 1'b0;
      hold <= '0;
    end else if (clear) begin
      bp   <= 1'b0;
    end else begin
      if (ld_state) bp <= ld_bp;
      else if (take_lo) bp <= 1'b1;
      else if (take_hi || pad) bp <= 1'b0;
      if (ld_hold) hold <= ld_hold_val;
      else if (take_lo) hold <= byte_in;
    end
  end

  assert_pair_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (take_hi && !clear && !ld_state) |=> !bp);
  assert_first_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (take_lo && !clear && !ld_state) |=> (bp && hold == $past(byte_in)));
  assert_pad_zero_R5: assert property (@(posedge clk) disable iff (rst)
    pad |-> (push_data[W-1:BW] == '0));
endmodule

// File: rtl/hwf_req.sv
module hwf_req #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             dir_drain,
  input  logic             flushing,
  input  logic             bp,
  input  logic [CNT_W-1:0] cnt,
  output logic             dma_req
);
  localparam int FREE_MIN = 2;
  localparam int HELD_MIN = 2;

  logic want;
  int   free_n;

  always_comb begin
    free_n = DEPTH - int'(cnt);
    if (!en)
      want = 1'b0;
    else if (dir_drain)
      want = (int'(cnt) >= HELD_MIN) || (flushing && (cnt != '0 || bp));
    else
      want = (free_n >= FREE_MIN);
  end

  always_ff @(posedge clk) begin
    if (rst) dma_req <= 1'b0;
    else     dma_req <= want;
  end

  assert_drain_req_R4: assert property (@(posedge clk) disable iff (rst)
    (en && dir_drain && !flushing && int'(cnt) < HELD_MIN) |=> !dma_req);
  assert_flush_req_R5: assert property (@(posedge clk) disable iff (rst)
    (en && dir_drain && flushing && (cnt != '0 || bp)) |=> dma_req);
  assert_fill_req_R9: assert property (@(posedge clk) disable iff (rst)
    (en && !dir_drain && cnt == '0) |=> dma_req);
endmodule

// File: rtl/hwf_top.sv
module hwf_top #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int BW    = W / 2,
  localparam int RA_W  = $clog2(DEPTH + 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            dir_drain,
  input  logic            flush,
  input  logic            sys_wr,
  input  logic [W-1:0]    sys_wdata,
  input  logic            sys_rd,
  input  logic            loc_byte_wr,
  input  logic [BW-1:0]   loc_byte,
  input  logic            loc_rd,
  output logic [W-1:0]    rd_data,
  output logic            dma_req,
  output logic            full,
  output logic            empty,
  input  logic            reg_wr,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [W-1:0]    reg_wdata,
  output logic [W-1:0]    reg_rdata
);
  import hwf_pkg::*;

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_LO = hwf_pkg::ctrl_cnt_lsb();
  localparam int WP_LO  = CNT_LO + CNT_W;
  localparam int RP_LO  = WP_LO + PTR_W;
  localparam int CTRL_BITS = RP_LO + PTR_W;
  localparam logic [RA_W-1:0] A_HOLD = RA_W'(DEPTH);
  localparam logic [RA_W-1:0] A_CTRL = RA_W'(DEPTH + 1);

  hwf_dir_e dir;
  logic [CNT_W-1:0] cnt;
  logic [PTR_W-1:0] wptr, rptr;
  logic [W-1:0] entry_q, reg_entry, pk_data, st_push_data;
  logic bp, pk_push, st_push, st_pop, clear, flushing;
  logic [BW-1:0] hold;
  logic reg_ok, we_entry, ld_state, ld_hold;
  logic [CTRL_BITS-1:0] ctrl_v;

  assign dir      = dir_drain ? DIR_DRAIN : DIR_FILL;
  assign clear    = en && (dir == DIR_FILL) && flush;
  assign reg_ok   = reg_wr && !en;
  assign we_entry = reg_ok && (reg_addr < A_HOLD);
  assign ld_hold  = reg_ok && (reg_addr == A_HOLD);
  assign ld_state = reg_ok && (reg_addr == A_CTRL);

  assign st_push      = en && ((dir == DIR_DRAIN) ? pk_push : sys_wr);
  assign st_push_data = (dir == DIR_DRAIN) ? pk_data : sys_wdata;
  assign st_pop       = en && ((dir == DIR_DRAIN) ? sys_rd : loc_rd);

  assign full  = (cnt == CNT_W'(DEPTH));
  assign empty = (cnt == '0);
  assign ctrl_v = {rptr, wptr, cnt, bp};

  hwf_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .clear(clear),
    .push(st_push), .push_data(st_push_data), .pop(st_pop),
    .ld_state(ld_state),
    .ld_cnt(reg_wdata[CNT_LO +: CNT_W]),
    .ld_wptr(reg_wdata[WP_LO +: PTR_W]),
    .ld_rptr(reg_wdata[RP_LO +: PTR_W]),
    .reg_we(we_entry), .reg_idx(reg_addr[PTR_W-1:0]), .reg_wdata(reg_wdata),
    .reg_entry(reg_entry),
    .cnt(cnt), .wptr(wptr), .rptr(rptr), .rd_q(entry_q)
  );

  hwf_pack #(.W(W)) u_pack (
    .clk(clk), .rst(rst), .clear(clear),
    .active(en && (dir == DIR_DRAIN)),
    .byte_wr(loc_byte_wr), .byte_in(loc_byte),
    .flushing(flushing), .full(full),
    .ld_state(ld_state), .ld_bp(reg_wdata[0]),
    .ld_hold(ld_hold), .ld_hold_val(reg_wdata[BW-1:0]),
    .bp(bp), .hold(hold), .push(pk_push), .push_data(pk_data)
  );

  hwf_req #(.DEPTH(DEPTH)) u_req (
    .clk(clk), .rst(rst), .en(en), .dir_drain(dir == DIR_DRAIN),
    .flushing(flushing), .bp(bp), .cnt(cnt), .dma_req(dma_req)
  );

  assign rd_data = entry_q;

  always_ff @(posedge clk) begin
    if (rst)
      flushing <= 1'b0;
    else if (en && (dir == DIR_DRAIN) && flush)
      flushing <= 1'b1;
    else if (flushing && empty && !bp)
      flushing <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)
      reg_rdata <= '0;
    else if (reg_addr == A_CTRL)
      reg_rdata <= W'(ctrl_v);
    else if (en)
      reg_rdata <= '0;
    else if (reg_addr == A_HOLD)
      reg_rdata <= {{BW{1'b0}}, hold};
    else if (reg_addr < A_HOLD)
      reg_rdata <= reg_entry;
    else
      reg_rdata <= '0;
  end

  assert_fill_flush_R6: assert property (@(posedge clk) disable iff (rst)
    (en && !dir_drain && flush) |=> (cnt == '0 && wptr == '0 && rptr == '0 && !bp));
  assert_reg_wr_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    (en && reg_wr && !sys_wr && !sys_rd && !loc_rd && !loc_byte_wr && !flush && !flushing)
      |=> ($stable(cnt) && $stable(wptr) && $stable(rptr) && $stable(bp) && $stable(hold)));
  assert_reg_rd_hidden_R7: assert property (@(posedge clk) disable iff (rst)
    (en && reg_addr != A_CTRL) |=> (reg_rdata == '0));
  assert_disabled_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!en && !reg_wr) |=> ($stable(cnt) && $stable(bp)));
endmodule

// File: tb/sim_hwf_top.sv
module sim_hwf_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, dir_drain = 1'b0, flush = 1'b0;
  logic sys_wr = 1'b0, sys_rd = 1'b0, loc_byte_wr = 1'b0, loc_rd = 1'b0, reg_wr = 1'b0;
  logic [15:0] sys_wdata = '0, reg_wdata = '0;
  logic [7:0]  loc_byte = '0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] rd_data, reg_rdata;
  logic dma_req, full, empty;

  int checks = 0, fails = 0;
  logic [15:0] exp_q[$];
  logic [15:0] mask_q[$];
  string tag_q[$];
  event pop_ev;
  logic [15:0] r;

  always #5 clk = ~clk;

  hwf_top u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(pop_ev) begin
    logic [15:0] e, m;
    string t;
    if (exp_q.size() == 0) chk(0, "scoreboard-empty", rd_data, 16'h0);
    else begin
      e = exp_q.pop_front(); m = mask_q.pop_front(); t = tag_q.pop_front();
      chk((rd_data & m) == (e & m), t, rd_data & m, e & m);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_item(input logic [15:0] v, input logic [15:0] m, input string t);
    exp_q.push_back(v); mask_q.push_back(m); tag_q.push_back(t);
  endtask

  task automatic sys_put(input logic [15:0] d);
    sys_wr = 1; sys_wdata = d; cyc(1); sys_wr = 0;
  endtask

  task automatic byte_put(input logic [7:0] b);
    loc_byte_wr = 1; loc_byte = b; cyc(1); loc_byte_wr = 0;
  endtask

  task automatic take(input bit sys_side, input bit scored);
    if (sys_side) sys_rd = 1; else loc_rd = 1;
    cyc(1); sys_rd = 0; loc_rd = 0;
    if (scored) ->pop_ev;
    #1;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [15:0] v);
    reg_addr = a; cyc(1); v = reg_rdata;
  endtask

  task automatic reg_put(input logic [2:0] a, input logic [15:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; cyc(1); reg_wr = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(3); rst = 0; cyc(1);
    // R1 reset state
    reg_rd(3'd5, r);
    chk(r == 16'h0, "R1 ctrl after reset", r, 16'h0);
    chk(empty && !full && !dma_req, "R1 empty/no request", {13'h0, empty, full, dma_req}, 16'h0004);

    // fill direction, R2 R9 R10
    en = 1; dir_drain = 0; cyc(2);
    chk(dma_req, "R9 request with all entries free", dma_req, 1);
    sys_put(16'h1111); sys_put(16'h2222); sys_put(16'h3333);
    cyc(2);
    chk(!dma_req, "R9 request drops with one free", dma_req, 0);
    sys_put(16'h4444);
    sys_put(16'h5555);
    chk(full, "R10 full after four", full, 1);
    reg_rd(3'd5, r);
    chk(r[3:1] == 3'd4, "R10 write on full ignored", r[3:1], 3'd4);
    expect_item(16'h1111, 16'hFFFF, "R2 order 0");
    expect_item(16'h2222, 16'hFFFF, "R2 order 1");
    expect_item(16'h3333, 16'hFFFF, "R2 order 2");
    expect_item(16'h4444, 16'hFFFF, "R10 fifth write dropped");
    for (int i = 0; i < 4; i++) take(0, 1);
    take(0, 0);
    chk(rd_data == 16'h4444, "R10 read on empty keeps data", rd_data, 16'h4444);
    reg_rd(3'd5, r);
    chk(r[3:1] == 3'd0, "R10 count stays zero", r[3:1], 3'd0);

    // R6 fill flush
    sys_put(16'hAAAA); sys_put(16'hBBBB);
    flush = 1; cyc(1); flush = 0;
    reg_rd(3'd5, r);
    chk(r[7:0] == 8'h0, "R6 flush clears state", r, 16'h0);
    chk(empty, "R6 empty after flush", empty, 1);
    sys_put(16'hCCCC);
    expect_item(16'hCCCC, 16'hFFFF, "R6 old data discarded");
    take(0, 1);

    // drain direction R3 R4
    dir_drain = 1; cyc(2);
    byte_put(8'hA1);
    reg_rd(3'd5, r);
    chk(r[0] == 1'b1, "R3 byte present after first byte", r[0], 1);
    byte_put(8'hB2);
    reg_rd(3'd5, r);
    chk(r[0] == 1'b0 && r[3:1] == 3'd1, "R3 pair pushed", r[3:0], 4'h2);
    cyc(2);
    chk(!dma_req, "R4 no request with one halfword", dma_req, 0);
    byte_put(8'hC3); byte_put(8'hD4);
    cyc(2);
    chk(dma_req, "R4 request with two halfwords", dma_req, 1);
    expect_item(16'hB2A1, 16'hFFFF, "R3 byte order first pair");
    take(1, 1);
    cyc(2);
    chk(!dma_req, "R4 request drops below two", dma_req, 0);

    // R5 drain flush with lone byte
    byte_put(8'h5E);
    flush = 1; cyc(1); flush = 0;
    cyc(3);
    chk(dma_req, "R5 request during flush", dma_req, 1);
    reg_rd(3'd5, r);
    chk(r[0] == 0 && r[3:1] == 3'd2, "R5 lone byte padded", r[3:0], 4'h4);
    expect_item(16'hD4C3, 16'hFFFF, "R3 byte order second pair");
    expect_item(16'h005E, 16'h00FF, "R5 padded low byte");
    take(1, 1);
    cyc(2);
    chk(dma_req, "R5 request held while data remains", dma_req, 1);
    take(1, 1);
    cyc(3);
    chk(!dma_req, "R5 request falls when drained", dma_req, 0);

    // R8 save/restore, R7 gating
    en = 0; cyc(1);
    reg_put(3'd0, 16'h1357); reg_put(3'd1, 16'h2468);
    reg_put(3'd2, 16'h9ABC); reg_put(3'd3, 16'hDEF0);
    reg_put(3'd4, 16'h005A);
    reg_put(3'd5, {8'h0, 2'd0, 2'd3, 3'd3, 1'b1});
    reg_rd(3'd2, r);
    chk(r == 16'h9ABC, "R8 entry readback", r, 16'h9ABC);
    reg_rd(3'd4, r);
    chk(r == 16'h005A, "R8 holding readback", r, 16'h005A);
    reg_rd(3'd5, r);
    chk(r[7:0] == 8'h37, "R8 control readback", r[7:0], 8'h37);
    en = 1; cyc(1);
    reg_rd(3'd0, r);
    chk(r == 16'h0, "R7 entry read hidden while enabled", r, 16'h0);
    reg_put(3'd0, 16'hFFFF);
    reg_put(3'd5, 16'h0000);
    reg_rd(3'd5, r);
    chk(r[7:0] == 8'h37, "R7 control write ignored", r[7:0], 8'h37);
    en = 0; cyc(1);
    reg_rd(3'd0, r);
    chk(r == 16'h1357, "R7 entry write ignored", r, 16'h1357);
    en = 1; dir_drain = 1; cyc(1);
    byte_put(8'h77);
    expect_item(16'h1357, 16'hFFFF, "R8 restored entry 0");
    expect_item(16'h2468, 16'hFFFF, "R8 restored entry 1");
    expect_item(16'h9ABC, 16'hFFFF, "R8 restored entry 2");
    expect_item(16'h775A, 16'hFFFF, "R8 restored holding byte");
    for (int i = 0; i < 4; i++) take(1, 1);
    reg_rd(3'd5, r);
    chk(r[3:0] == 4'h0, "R8 drained to empty", r[3:0], 4'h0);

    cyc(2);
    chk(exp_q.size() == 0, "scoreboard drained", 16'(exp_q.size()), 16'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule